// File: doc/BRIEF.md
# Serial MII Transmit Segment Serializer

This block sits at the MAC end of a serial MII link and turns a stream of MII-style transmit nibbles into the single serial transmit line and its SYNC marker. One reference clock drives everything. The line carries one bit per clock, grouped into 10-bit segments, and SYNC marks the first bit of each segment. Bit 0 of a segment is the error flag, bit 1 is the enable flag, and bits 2 to 9 carry one data byte, least significant bit first.

Nibbles arrive on a valid/ready handshake in the reference clock domain. Each nibble is tagged with an enable flag and an error flag. The block pairs enabled nibbles into bytes, taking the low nibble first. A nibble offered with its enable flag low is an end-of-frame marker. If the marker finds an unpaired nibble waiting, that nibble is padded into a full byte with the error flag set.

In fast mode every segment carries a fresh byte. In slow mode each byte is sent on ten consecutive segments. A new byte is loaded only at the boundary of a ten-segment group. When no byte is waiting at a load point, the segment sent is all zeros.

Top module: `smii_tx_serializer`

## Requirements
- R1: After reset is released, `smii_sync` is high for exactly one clock in every 10, starting on the first clock after release, and it is free-running.
- R2: The segment bit sent k clocks after a SYNC clock (SYNC clock is k=0) is: k=0 error flag, k=1 enable flag, k=2..9 data byte bits 0..7 in that order.
- R3: Two enabled nibbles form one byte: the first accepted nibble becomes byte bits 3:0 and the second becomes bits 7:4. The byte's error flag is the OR of the two nibbles' error flags.
- R4: In fast mode (`fast_mode`=1), each segment loads the next waiting byte, so a continuously fed frame produces back-to-back enabled segments.
- R5: In slow mode (`fast_mode`=0), each byte is sent on exactly ten consecutive segments, and no byte is cut short by an idle segment.
- R6: A segment that carries no byte is all zero, including its error, enable and data bits.
- R7: `nib_ready` is low while a completed byte waits for its load point. It is low on the clock right after a byte is completed. Nibbles offered while it is low are not taken.
- R8: An accepted nibble with `nib_en`=0 closes the frame. If one nibble is pending, it is sent as byte {4'h0, pending} with the error flag set. With nothing pending, the marker produces no segment.
- R9: While `rst_n` is low (synchronous, active low), `smii_txd`, `smii_sync` and `nib_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_mode | input | 1 | 1: new byte every segment; 0: each byte held for ten segments |
| nib_valid | input | 1 | Nibble offered |
| nib_ready | output | 1 | Nibble will be taken this cycle if valid |
| nib_en | input | 1 | Nibble belongs to a frame; low marks frame end |
| nib_er | input | 1 | Error flag attached to the nibble |
| nib_data | input | 4 | Nibble value |
| smii_sync | output | 1 | Segment start marker, one clock per segment |
| smii_txd | output | 1 | Serial transmit line |

## Verification
Faults in the bit counter show up within one segment, as SYNC at the wrong spacing or as control bits moved into the data field. Faults in the slow-mode repeat counter show up within one ten-segment group, as a byte sent a wrong number of times or broken by idle segments. Faults in the nibble buffer or pairing state show up on the next completed byte. They appear as swapped or stale nibbles, a lost error flag, a byte missing from the scoreboard or an extra one, or a ready signal still high right after a byte is completed.

// File: rtl/smii_tx_pkg.sv
package smii_tx_pkg;
    // fixed positions of the control flags inside a segment
    localparam int CTRL_BITS = 2;
    localparam int ER_POS    = 0;
    localparam int EN_POS    = 1;
endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer #(
    parameter int SEG_LEN   = 10,
    parameter int REP_COUNT = 10,
    localparam int BW = $clog2(SEG_LEN),
    localparam int RW = $clog2(REP_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast,
    output logic [BW-1:0] bit_next,
    output logic          load_slot
);
    typedef struct packed {
        logic [BW-1:0] bit_idx;
        logic [RW-1:0] rep;
    } tmr_t;

    tmr_t s_d, s_q;
    logic last_bit;

    always_comb begin
        s_d      = s_q;
        last_bit = (s_q.bit_idx == BW'(SEG_LEN - 1));
        if (last_bit) begin
            s_d.bit_idx = '0;
            if (fast || s_q.rep == RW'(REP_COUNT - 1))
                s_d.rep = '0;
            else
                s_d.rep = s_q.rep + 1'b1;
        end else begin
            s_d.bit_idx = s_q.bit_idx + 1'b1;
        end
        load_slot = last_bit && (fast || s_q.rep == RW'(REP_COUNT - 1));
        bit_next  = s_d.bit_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.bit_idx <= BW'(SEG_LEN - 1);
            s_q.rep     <= RW'(REP_COUNT - 1);
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/smii_nib_pack.sv
module smii_nib_pack #(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nib_valid,
    input  logic              nib_en,
    input  logic              nib_er,
    input  logic [NIB_W-1:0]  nib_data,
    output logic              nib_ready,
    input  logic              take,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_er
);
    typedef struct packed {
        logic              lo_vld;
        logic [NIB_W-1:0]  lo_data;
        logic              lo_er;
        logic              buf_vld;
        logic [BYTE_W-1:0] buf_data;
        logic              buf_er;
    } pk_t;

    pk_t  s_d, s_q;
    logic accept;

    assign nib_ready = rst_n && !s_q.buf_vld;
    assign accept    = nib_valid && nib_ready;
    assign byte_vld  = s_q.buf_vld;
    assign byte_data = s_q.buf_data;
    assign byte_er   = s_q.buf_er;

    always_comb begin
        s_d = s_q;
        if (take)
            s_d.buf_vld = 1'b0;
        if (accept) begin
            if (nib_en) begin
                if (!s_q.lo_vld) begin
                    s_d.lo_vld  = 1'b1;
                    s_d.lo_data = nib_data;
                    s_d.lo_er   = nib_er;
                end else begin
                    s_d.lo_vld   = 1'b0;
                    s_d.buf_vld  = 1'b1;
                    s_d.buf_data = {nib_data, s_q.lo_data};
                    s_d.buf_er   = s_q.lo_er | nib_er;
                end
            end else if (s_q.lo_vld) begin
                // frame closed on an odd nibble: pad and flag the byte
                s_d.lo_vld   = 1'b0;
                s_d.buf_vld  = 1'b1;
                s_d.buf_data = {{NIB_W{1'b0}}, s_q.lo_data};
                s_d.buf_er   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end
endmodule

// File: rtl/smii_tx_serializer.sv
module smii_tx_serializer #(
    parameter int NIB_W     = 4,
    parameter int REP_COUNT = 10,
    localparam int BYTE_W  = 2 * NIB_W,
    localparam int SEG_LEN = BYTE_W + smii_tx_pkg::CTRL_BITS,
    localparam int BW      = $clog2(SEG_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode,
    input  logic             nib_valid,
    output logic             nib_ready,
    input  logic             nib_en,
    input  logic             nib_er,
    input  logic [NIB_W-1:0] nib_data,
    output logic             smii_sync,
    output logic             smii_txd
);
    import smii_tx_pkg::*;

    typedef struct packed {
        logic [SEG_LEN-1:0] seg;
        logic               txd;
        logic               sync;
    } ser_t;

    ser_t              s_d, s_q;
    logic [BW-1:0]     bit_next;
    logic              load_slot;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_er;
    logic              take;

    smii_seg_timer #(.SEG_LEN(SEG_LEN), .REP_COUNT(REP_COUNT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast      (fast_mode),
        .bit_next  (bit_next),
        .load_slot (load_slot)
    );

    assign take = load_slot && byte_vld;

    smii_nib_pack #(.NIB_W(NIB_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .nib_valid (nib_valid),
        .nib_en    (nib_en),
        .nib_er    (nib_er),
        .nib_data  (nib_data),
        .nib_ready (nib_ready),
        .take      (take),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_er   (byte_er)
    );

    always_comb begin
        s_d = s_q;
        if (load_slot) begin
            s_d.seg = '0;
            if (byte_vld) begin
                s_d.seg[ER_POS]               = byte_er;
                s_d.seg[EN_POS]               = 1'b1;
                s_d.seg[SEG_LEN-1:CTRL_BITS]  = byte_data;
            end
        end
        s_d.txd  = s_d.seg[bit_next];
        s_d.sync = (bit_next == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign smii_sync = s_q.sync;
    assign smii_txd  = s_q.txd;
endmodule

// File: rtl/smii_tx_serializer_chk.sv
module smii_tx_serializer_chk #(
    parameter int SEG_LEN = 10
) (
    input logic clk,
    input logic rst_n,
    input logic smii_sync,
    input logic smii_txd
);
    logic [3:0] last_pos_q;
    logic [3:0] cur_pos;
    logic       seen_q;
    logic       en_q;

    assign cur_pos = smii_sync ? 4'd0 : last_pos_q + 4'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pos_q <= '0;
            seen_q     <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            last_pos_q <= cur_pos;
            if (smii_sync)
                seen_q <= 1'b1;
            if (cur_pos == 4'd1)
                en_q <= smii_txd;
        end
    end

    assert_sync_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        smii_sync |=> !smii_sync);

    assert_sync_on_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && last_pos_q == 4'(SEG_LEN - 1)) |-> smii_sync);

    assert_sync_not_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && smii_sync) |-> (last_pos_q == 4'(SEG_LEN - 1)));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !smii_sync && cur_pos >= 4'd2 && !en_q) |-> !smii_txd);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!smii_txd && !smii_sync));
endmodule

bind smii_tx_serializer smii_tx_serializer_chk #(.SEG_LEN(SEG_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smii_sync (smii_sync),
    .smii_txd  (smii_txd)
);

// File: tb/smii_tx_serializer_tb.sv
module smii_tx_serializer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast_mode = 1'b1;
    logic       nib_valid = 1'b0;
    logic       nib_en = 1'b0;
    logic       nib_er = 1'b0;
    logic [3:0] nib_data = 4'h0;
    logic       nib_ready;
    logic       smii_sync;
    logic       smii_txd;

    int n_vec = 0;
    int n_bad = 0;
    int n_unexp = 0;
    bit done = 0;

    logic [9:0] exp_q[$];
    bit         mon_on = 0;
    int         pos = 10;
    logic [9:0] seg_acc = '0;
    int         rep_cnt = 0;
    bit         prev_en = 0;

    always #5 clk = ~clk;

    smii_tx_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_mode (fast_mode),
        .nib_valid (nib_valid),
        .nib_ready (nib_ready),
        .nib_en    (nib_en),
        .nib_er    (nib_er),
        .nib_data  (nib_data),
        .smii_sync (smii_sync),
        .smii_txd  (smii_txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard compare of one finished segment
    task automatic check_seg(input logic [9:0] seg);
        if (seg[1]) begin
            if (exp_q.size() == 0) begin
                n_unexp++;
                chk(1'b0, "R8 unexpected byte segment", int'(seg), 0);
            end else begin
                chk(seg == exp_q[0], "R2/R3 segment content", int'(seg), int'(exp_q[0]));
                if (fast_mode) begin
                    void'(exp_q.pop_front());
                end else begin
                    rep_cnt++;
                    if (rep_cnt == 10) begin
                        void'(exp_q.pop_front());
                        rep_cnt = 0;
                    end
                end
            end
        end else begin
            chk(seg == 10'h0, "R6 idle segment all zero", int'(seg), 0);
            if (!fast_mode && rep_cnt != 0) begin
                chk(1'b0, "R5 repeat group cut short", rep_cnt, 10);
                rep_cnt = 0;
            end
            if (fast_mode && prev_en && exp_q.size() != 0)
                chk(1'b0, "R4 gap inside fast frame", 0, 1);
        end
        prev_en = seg[1];
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (smii_sync) pos = 0;
            if (pos < 10) begin
                seg_acc[pos] = smii_txd;
                if (pos == 9) check_seg(seg_acc);
                pos = pos + 1;
            end
        end
    end

    // called at a negedge; returns at the negedge after acceptance
    task automatic send_nib(input bit en, input bit er, input logic [3:0] d);
        nib_valid = 1'b1;
        nib_en    = en;
        nib_er    = er;
        nib_data  = d;
        while (!nib_ready) @(negedge clk);
        @(negedge clk);
        nib_valid = 1'b0;
    endtask

    task automatic send_frame(input int n, input int seed, input int er_idx);
        logic [3:0] lo = 4'h0;
        bit         lo_er = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [3:0] d = 4'((seed + 3 * k) & 15);
            bit e = (k == er_idx);
            send_nib(1'b1, e, d);
            if (k % 2 == 0) begin
                lo = d;
                lo_er = e;
            end else begin
                exp_q.push_back({d, lo, 1'b1, lo_er | e});
                chk(nib_ready == 1'b0, "R7 ready low after byte completed", int'(nib_ready), 0);
            end
        end
        send_nib(1'b0, 1'b0, 4'h0);
        if (n % 2 == 1) begin
            exp_q.push_back({4'h0, lo, 1'b1, 1'b1});
            chk(nib_ready == 1'b0, "R8 ready low after pad byte", int'(nib_ready), 0);
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: quiet outputs during reset
        chk(smii_txd == 1'b0, "R9 txd low in reset", int'(smii_txd), 0);
        chk(smii_sync == 1'b0, "R9 sync low in reset", int'(smii_sync), 0);
        chk(nib_ready == 1'b0, "R9 ready low in reset", int'(nib_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(smii_sync == 1'b1, "R1 first sync after release", int'(smii_sync), 1);
        chk(nib_ready == 1'b1, "R7 ready high with empty buffer", int'(nib_ready), 1);
        mon_on = 1;
        pos = 0;
        seg_acc[0] = smii_txd;
        pos = 1;
        // R1 spacing: the next sync comes exactly ten clocks later
        repeat (9) begin
            @(negedge clk);
            chk(smii_sync == 1'b0, "R1 no sync mid segment", int'(smii_sync), 0);
        end
        @(negedge clk);
        chk(smii_sync == 1'b1, "R1 sync period ten", int'(smii_sync), 1);

        // fast mode: R4, R3, R8
        send_frame(8, 1, -1);
        send_frame(7, 5, -1);
        send_frame(6, 11, 3);
        // R8: marker with nothing pending yields no segment
        send_nib(1'b0, 1'b1, 4'hF);
        repeat (40) @(negedge clk);
        chk(n_unexp == 0, "R8 lone marker produced nothing", n_unexp, 0);

        // slow mode: R5
        fast_mode = 1'b0;
        repeat (200) @(negedge clk);
        send_frame(4, 9, -1);
        send_frame(3, 2, 0);
        repeat (250) @(negedge clk);

        chk(exp_q.size() == 0, "R5 all expected bytes sent", exp_q.size(), 0);
        chk(n_unexp == 0, "R8 no unexpected bytes", n_unexp, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule